// File: doc/BRIEF.md
# Key-Gated Independent Watchdog Timer

This block is a watchdog timer that runs on its own slow clock. A 12-bit down-counter advances once per divided tick. The tick comes from a power-of-two prescaler that divides by 4 up to 256. When the count runs out, the block raises a reset request for one cycle and records that it did so in a sticky status flag. Software must refresh the counter before that happens.

Every control action is a write of a 16-bit magic value to a key register. One value opens the divider and reload registers for writing, and any other key value closes them again. A second value refreshes the counter. A third value arms the timer, and once armed the timer can only be disarmed by a system reset.

New divider or reload settings are only latched at a refresh or an arm. A count already in progress therefore finishes with the settings it started with.

Top module: `kwd_top`

## Requirements
- R1: After reset, `wdt_reset_req` is low and the timer is disarmed. The bus reads as follows:
  - address 0 (key) reads 0;
  - address 1 (divider code, bits 2:0) reads 0;
  - address 2 (reload value, bits 11:0) reads 0xFFF;
  - address 3 (status) reads 0, where bit 0 is armed and bit 1 is the expiry flag.
- R2: Writing key 0x5555 to address 0 opens addresses 1 and 2 for writing. Any other key value closes them. Writes to addresses 1 and 2 while they are closed leave the stored values unchanged.
- R3: Writing key 0xCCCC arms the timer, so status bit 0 reads 1. No key value disarms it.
- R4: While the timer is disarmed, `wdt_reset_req` never asserts.
- R5: With latched reload value R and divider D, the first `wdt_reset_req` rises R×D clock edges after the edge that takes a refresh or arm key. A reload value of 0 behaves as 1.
- R6: The divider code selects D. Codes 0 to 6 give D = 4 << code, and code 7 gives 256.
- R7: `wdt_reset_req` stays high for exactly one cycle. The count then restarts from the latched values, so the next request follows R×D edges later if no key is written.
- R8: The expiry flag (status bit 1) sets after a request and stays set until reset.
- R9: Changed divider or reload values do not alter a count in progress. They apply from the next refresh or arm key.
- R10: Writing key 0xAAAA restarts the count from the stored reload value. Refreshing more often than every R×D edges prevents any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 key, 1 divider code, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong internal state shows first as a request edge at the wrong cycle. Each timeout is therefore measured edge-exact, from the key write to the rising request. A prescaler or counter that is off by one moves that edge by D cycles, or by one cycle, within a single period.

A write lock that is wrongly open or closed shows up in the very next read of the divider or reload register. Settings latched at the wrong moment are caught by measuring the period that follows a mid-count reconfiguration. That period must still equal the old value minus the cycles the writes took.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_ARM     = 16'hCCCC;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY    = 2'd0,
        REG_DIV    = 2'd1,
        REG_RELOAD = 2'd2,
        REG_STATUS = 2'd3
    } kwd_reg_e;

    typedef struct packed {
        logic expired;
        logic armed;
    } kwd_status_t;

    // Shift amount of the divider: min_sh + code, saturated at max_sh.
    function automatic int unsigned kwd_shift(input int unsigned code,
                                              input int unsigned min_sh,
                                              input int unsigned max_sh);
        int unsigned s;
        s = min_sh + code;
        if (s > max_sh) s = max_sh;
        return s;
    endfunction

endpackage

// File: rtl/kwd_keyctrl.sv
module kwd_keyctrl
    import kwd_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic              unlocked,
    output logic              armed,
    output logic [CODE_W-1:0] div_code,
    output logic [CNT_W-1:0]  reload_val,
    output logic              load
);

    logic key_hit;

    assign key_hit = bus_wr && (bus_addr == REG_KEY);
    assign load    = key_hit && ((bus_wdata == KEY_REFRESH) || (bus_wdata == KEY_ARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked   <= 1'b0;
            armed      <= 1'b0;
            div_code   <= '0;
            reload_val <= '1;
        end else begin
            if (key_hit) begin
                unlocked <= (bus_wdata == KEY_OPEN);
                if (bus_wdata == KEY_ARM) armed <= 1'b1;
            end
            if (bus_wr && unlocked && (bus_addr == REG_DIV))
                div_code <= bus_wdata[CODE_W-1:0];
            if (bus_wr && unlocked && (bus_addr == REG_RELOAD))
                reload_val <= bus_wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
    import kwd_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int MIN_SH = 2,
    parameter int MAX_SH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic              tick
);

    logic [CODE_W-1:0] act_code;
    logic [MAX_SH-1:0] pre_cnt;
    logic [MAX_SH-1:0] limit;
    int unsigned       sh;

    always_comb begin
        sh    = kwd_shift(32'(act_code), MIN_SH, MAX_SH);
        limit = {MAX_SH{1'b1}} >> (MAX_SH - sh);
    end

    assign tick = run && !load && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code <= '0;
            pre_cnt  <= '0;
        end else if (load) begin
            act_code <= code_in;
            pre_cnt  <= '0;
        end else if (run) begin
            if (pre_cnt == limit) pre_cnt <= '0;
            else                  pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_in,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_reload;
    logic             last;

    assign last = (cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '1;
            act_reload <= '1;
            expire     <= 1'b0;
        end else if (load) begin
            cnt        <= reload_in;
            act_reload <= reload_in;
            expire     <= 1'b0;
        end else if (tick) begin
            expire <= last;
            cnt    <= last ? act_reload : cnt - 1'b1;
        end else begin
            expire <= 1'b0;
        end
    end

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int CODE_W = 3,
    parameter int MIN_SH = 2,
    parameter int MAX_SH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdt_reset_req
);

    logic              unlocked_q;
    logic              run_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  reload_q;
    logic              load;
    logic              tick;
    logic              cause_q;
    kwd_status_t       stat;

    kwd_keyctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_key (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .unlocked   (unlocked_q),
        .armed      (run_q),
        .div_code   (code_q),
        .reload_val (reload_q),
        .load       (load)
    );

    kwd_prescaler #(.CODE_W(CODE_W), .MIN_SH(MIN_SH), .MAX_SH(MAX_SH)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .load    (load),
        .code_in (code_q),
        .tick    (tick)
    );

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .tick      (tick),
        .reload_in (reload_q),
        .expire    (wdt_reset_req)
    );

    always_ff @(posedge clk) begin
        if (rst) cause_q <= 1'b0;
        else     cause_q <= cause_q | wdt_reset_req;
    end

    assign stat.armed   = run_q;
    assign stat.expired = cause_q;

    always_comb begin
        case (bus_addr)
            REG_DIV:    bus_rdata = {{(KEY_W-CODE_W){1'b0}}, code_q};
            REG_RELOAD: bus_rdata = {{(KEY_W-CNT_W){1'b0}}, reload_q};
            REG_STATUS: bus_rdata = {{(KEY_W-2){1'b0}}, stat};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              rst_req,
    input logic              run,
    input logic              cause,
    input logic              unlocked,
    input logic [CODE_W-1:0] code_reg
);

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !run |-> !rst_req);

    assert_run_hold_R3: assert property (@(posedge clk) disable iff (rst)
        run |=> run);

    assert_start_arms_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'hCCCC) |=> run);

    assert_cause_set_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> cause);

    assert_cause_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cause |=> cause);

    assert_locked_div_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && !unlocked) |=> $stable(code_reg));

    assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_wdata != 16'h5555) |=> !unlocked);

endmodule

bind kwd_top kwd_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rst_req   (wdt_reset_req),
    .run       (run_q),
    .cause     (cause_q),
    .unlocked  (unlocked_q),
    .code_reg  (code_q)
);

// File: tb/sim_kwd_top.sv
`timescale 1ns/1ps
module sim_kwd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        wdt_reset_req;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    kwd_top u0 (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .wdt_reset_req (wdt_reset_req)
    );

    // {divider code, reload value}
    localparam logic [14:0] VEC [8] = '{
        {3'd0, 12'd5}, {3'd1, 12'd3}, {3'd2, 12'd2}, {3'd6, 12'd2},
        {3'd7, 12'd2}, {3'd3, 12'd0}, {3'd5, 12'd10}, {3'd4, 12'd7}
    };

    function automatic int div_of(input int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    function automatic int period(input int code, input int rl);
        return ((rl == 0) ? 1 : rl) * div_of(code);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_fire(input int limit, output int fired, output int n);
        fired = 0;
        n = 0;
        while (n < limit && fired == 0) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (wdt_reset_req) fired = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int v, f, n, exp;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 req", int'(wdt_reset_req), 0);
        rd(2'd3, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 div", v, 0);
        rd(2'd2, v); chk("R1 reload", v, 'hFFF);
        rd(2'd0, v); chk("R1 key read", v, 0);

        // R2 locked write ignored
        wr(2'd1, 16'd3);
        rd(2'd1, v); chk("R2 locked div", v, 0);

        // R4 disarmed: no request
        wait_fire(17000, f, n);
        chk("R4 idle fired", f, 0);

        // R3 arm, R5 default period
        wr(2'd0, 16'hCCCC);
        rd(2'd3, v); chk("R3 armed bit", v & 1, 1);
        wait_fire(20000, f, n);
        chk("R5 default fired", f, 1);
        chk("R5 default period", n, 4095 * 4);
        @(negedge clk);
        chk("R7 pulse width", int'(wdt_reset_req), 0);
        rd(2'd3, v); chk("R8 cause set", (v >> 1) & 1, 1);

        // R5/R6 vector table
        for (int i = 0; i < 8; i++) begin
            int code, rl;
            code = int'(VEC[i][14:12]);
            rl   = int'(VEC[i][11:0]);
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(code));
            wr(2'd2, 16'(rl));
            wr(2'd0, 16'hAAAA);
            exp = period(code, rl);
            wait_fire(5000, f, n);
            chk($sformatf("R5 R6 vec%0d period", i), n, exp);
            @(negedge clk);
            chk($sformatf("R7 vec%0d width", i), int'(wdt_reset_req), 0);
        end

        // R7 auto restart with latched values (code 4, reload 7)
        wait_fire(5000, f, n);
        chk("R7 repeat period", n, 448 - 1);

        // R9 new reload does not disturb running count
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd3);
        rd(2'd2, v); chk("R2 open reload write", v, 3);
        wait_fire(5000, f, n);
        chk("R9 old period kept", n, 448 - 2);

        // R10 refresh picks up new value
        wr(2'd0, 16'hAAAA);
        wait_fire(5000, f, n);
        chk("R10 new period", n, 3 * 64);

        // R2 relock, R3 not stoppable
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd50);
        rd(2'd2, v); chk("R2 relocked reload", v, 3);
        wr(2'd0, 16'h0000);
        rd(2'd3, v); chk("R3 still armed", v & 1, 1);
        wait_fire(5000, f, n);
        chk("R3 still fires", n, 192 - 3);

        // R10 frequent refresh prevents request
        for (int k = 0; k < 5; k++) begin
            wait_fire(100, f, n);
            chk("R10 refreshed no fire", f, 0);
            wr(2'd0, 16'hAAAA);
        end
        rd(2'd3, v); chk("R8 cause sticky", (v >> 1) & 1, 1);

        // R1 reset returns to idle
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(2'd3, v); chk("R1 status after reset", v, 0);
        rd(2'd2, v); chk("R1 reload after reset", v, 'hFFF);
        chk("R1 req after reset", int'(wdt_reset_req), 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule